// File: doc/BRIEF.md
# Sampled Three-State Phase-Frequency Detector with Charge Model

This block compares two slow clock-like signals, a reference and a feedback, inside a fast synchronous system clock domain. Both inputs are synchronized and their rising edges are detected. A three-state machine then drives two pulse outputs, `up` and `dn`, whose widths in system-clock cycles follow the phase error. `up` is asserted while the reference is ahead, `dn` while it is behind. The machine also acts as a frequency detector. When one input runs faster, pulses appear only in the direction that would pull the feedback toward it.

The block also models charge-pump action in the digital domain. Each cycle it produces a signed pump value: plus the programmed magnitude while `up` is high, minus it while `dn` is high, and zero otherwise. A saturating signed accumulator integrates that value as a stand-in for the charge delivered to a loop filter. A lock indicator reports when a run of reference periods has passed with every pulse no wider than a programmable threshold.

Top module: `pfd_pump_top`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `up`, `dn` and `locked` are 0, `pump_val` is 0 and `charge` is 0.
- R2: Each input passes through a two-flop synchronizer and a rising-edge detector. A 0-to-1 input change, applied between clock edges, first shows on `up`/`dn` after the third following rising clock edge. The outputs change only in a cycle that follows a detected edge.
- R3: `up` and `dn` are never 1 in the same cycle.
- R4: A reference rise that leads the feedback rise by D cycles gives a single `up` pulse of exactly D cycles. A feedback rise leading by D gives a single `dn` pulse of D cycles.
- R5: From neutral, a reference edge enters the UP state and a feedback edge enters the DOWN state. From UP, a feedback edge returns to neutral and a repeated reference edge stays in UP. From DOWN, a reference edge returns to neutral and a repeated feedback edge stays in DOWN.
- R6: Reference and feedback edges detected in the same cycle send the machine to neutral, so no pulse appears.
- R7: With the reference faster than the feedback, `dn` is never asserted and `charge` grows positive. With the reference slower, `up` is never asserted and `charge` goes negative.
- R8: `pump_val` is a signed (MAG_W+1)-bit value: +`pump_mag` while `up` is 1, −`pump_mag` while `dn` is 1, and 0 otherwise.
- R9: `charge` adds the previous cycle's `pump_val` on every clock. A pulse of W cycles at magnitude M therefore changes `charge` by ±W·M.
- R10: `charge` is a signed 24-bit value that saturates at +8388607 and −8388608 and never wraps.
- R11: `locked` rises after 16 consecutive reference edges, each closing a period in which no `up`/`dn` pulse was wider than `lock_thr` cycles. A pulse wider than `lock_thr` clears `locked` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the compared signals |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to `clk` |
| ref_in | input | 1 | Reference signal, asynchronous to `clk` |
| fb_in | input | 1 | Feedback signal, asynchronous to `clk` |
| pump_mag | input | MAG_W (8) | Unsigned pump magnitude, used for both directions |
| lock_thr | input | THR_W (6) | Widest pulse in cycles still counted as in lock |
| up | output | 1 | Pump-up pulse, high while the reference leads |
| dn | output | 1 | Pump-down pulse, high while the reference lags |
| pump_val | output | MAG_W+1 (9) | Signed per-cycle pump value |
| charge | output | ACC_W (24) | Signed, saturating integral of `pump_val` |
| locked | output | 1 | Lock indicator |

## Verification
Every cycle, the assertions check that the pulses are mutually exclusive, that the pulses hold still when no edge was detected, and that an edge in one direction clears the pulse of the other. They also check that coincident edges leave both pulses low, that `charge` never moves against the sign of the pump value, and that lock can only rise right after a reference edge. Only the bench's scenarios can show the exact pulse widths for each lead and lag, the charge totals, and saturation at both limits. The same holds for the frequency-detector behaviour with unequal periods and for the lock threshold boundary, where the bench compares a width equal to the threshold with one cycle more.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

  // Three detector states; the encoding keeps one bit per pulse direction.
  typedef enum logic [1:0] {
    PFD_IDLE = 2'b00,
    PFD_DOWN = 2'b01,
    PFD_UP   = 2'b10
  } pfd_state_e;

  localparam int unsigned PFD_CH_REF = 0;
  localparam int unsigned PFD_CH_FB  = 1;
  localparam int unsigned PFD_NCH    = 2;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);

  // sh_q[STAGES-1] is the synchronized value, sh_q[STAGES] its one-cycle delay.
  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  always_comb begin
    rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  end

endmodule

// File: rtl/pfd_fsm.sv
module pfd_fsm
  import pfd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ref_edge,
  input  logic fb_edge,
  output logic up,
  output logic dn
);

  pfd_state_e state_q;
  pfd_state_e state_d;
  logic       state_en;

  // The state advances only in cycles with a detected edge.
  always_comb begin
    state_en = ref_edge | fb_edge;
  end

  always_comb begin
    state_d = state_q;
    if (ref_edge && fb_edge) begin
      state_d = PFD_IDLE;
    end else begin
      unique case (state_q)
        PFD_IDLE: begin
          if (ref_edge)     state_d = PFD_UP;
          else if (fb_edge) state_d = PFD_DOWN;
        end
        PFD_UP: begin
          if (fb_edge) state_d = PFD_IDLE;
        end
        PFD_DOWN: begin
          if (ref_edge) state_d = PFD_IDLE;
        end
        default: state_d = PFD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PFD_IDLE;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  always_comb begin
    up = (state_q == PFD_UP);
    dn = (state_q == PFD_DOWN);
  end

endmodule

// File: rtl/pfd_charge.sv
module pfd_charge #(
  parameter int unsigned MAG_W = 8,
  parameter int unsigned ACC_W = 24
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    up,
  input  logic                    dn,
  input  logic [MAG_W-1:0]        pump_mag,
  output logic signed [MAG_W:0]   pump_val,
  output logic signed [ACC_W-1:0] charge
);

  localparam int unsigned EXT_W = ACC_W + 1;
  localparam logic signed [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

  logic signed [MAG_W:0]   mag_s;
  logic signed [EXT_W-1:0] pump_ext;
  logic signed [EXT_W-1:0] sum;
  logic signed [ACC_W-1:0] charge_d;
  logic signed [ACC_W-1:0] charge_q;

  always_comb begin
    mag_s = $signed({1'b0, pump_mag});
    if (up)      pump_val = mag_s;
    else if (dn) pump_val = -mag_s;
    else         pump_val = '0;
  end

  // One guard bit above the accumulator detects overflow in either direction.
  always_comb begin
    pump_ext = {{(EXT_W-MAG_W-1){pump_val[MAG_W]}}, pump_val};
    sum      = {charge_q[ACC_W-1], charge_q} + pump_ext;
    if (sum[EXT_W-1] != sum[EXT_W-2]) begin
      charge_d = sum[EXT_W-1] ? ACC_MIN : ACC_MAX;
    end else begin
      charge_d = sum[ACC_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      charge_q <= '0;
    end else begin
      charge_q <= charge_d;
    end
  end

  always_comb begin
    charge = charge_q;
  end

endmodule

// File: rtl/pfd_lock_mon.sv
module pfd_lock_mon #(
  parameter int unsigned THR_W        = 6,
  parameter int unsigned LOCK_PERIODS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_edge,
  input  logic             up,
  input  logic             dn,
  input  logic [THR_W-1:0] lock_thr,
  output logic             locked
);

  localparam int unsigned CNT_W = $clog2(LOCK_PERIODS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(LOCK_PERIODS);
  localparam logic [THR_W-1:0] WID_TOP = {THR_W{1'b1}};

  logic             pulse;
  logic             viol;
  logic [THR_W-1:0] wid_q;
  logic [THR_W-1:0] wid_d;
  logic             bad_q;
  logic             bad_d;
  logic [CNT_W-1:0] good_q;
  logic [CNT_W-1:0] good_d;

  // wid_q counts earlier cycles of the current pulse, so the pulse exceeds
  // the threshold in the cycle where wid_q has already reached it.
  always_comb begin
    pulse = up | dn;
    viol  = pulse && (wid_q >= lock_thr);
    if (!pulse)                wid_d = '0;
    else if (wid_q == WID_TOP) wid_d = WID_TOP;
    else                       wid_d = wid_q + 1'b1;
  end

  always_comb begin
    bad_d  = bad_q | viol;
    good_d = good_q;
    if (ref_edge) begin
      bad_d = 1'b0;
      if (bad_q || viol)         good_d = '0;
      else if (good_q != CNT_TOP) good_d = good_q + 1'b1;
    end else if (viol) begin
      good_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wid_q  <= '0;
      bad_q  <= 1'b0;
      good_q <= '0;
    end else begin
      wid_q  <= wid_d;
      bad_q  <= bad_d;
      good_q <= good_d;
    end
  end

  always_comb begin
    locked = (good_q == CNT_TOP);
  end

endmodule

// File: rtl/pfd_pump_top.sv
module pfd_pump_top
  import pfd_pkg::*;
#(
  parameter int unsigned MAG_W        = 8,
  parameter int unsigned ACC_W        = 24,
  parameter int unsigned THR_W        = 6,
  parameter int unsigned LOCK_PERIODS = 16,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_in,
  input  logic                    fb_in,
  input  logic [MAG_W-1:0]        pump_mag,
  input  logic [THR_W-1:0]        lock_thr,
  output logic                    up,
  output logic                    dn,
  output logic signed [MAG_W:0]   pump_val,
  output logic signed [ACC_W-1:0] charge,
  output logic                    locked
);

  logic [PFD_NCH-1:0] raw_in;
  logic [PFD_NCH-1:0] edge_v;
  logic               ref_edge;
  logic               fb_edge;

  always_comb begin
    raw_in[PFD_CH_REF] = ref_in;
    raw_in[PFD_CH_FB]  = fb_in;
  end

  for (genvar g = 0; g < PFD_NCH; g++) begin : g_chan
    pfd_edge_sync #(
      .STAGES (SYNC_STAGES)
    ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (raw_in[g]),
      .rise  (edge_v[g])
    );
  end

  always_comb begin
    ref_edge = edge_v[PFD_CH_REF];
    fb_edge  = edge_v[PFD_CH_FB];
  end

  pfd_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_edge (ref_edge),
    .fb_edge  (fb_edge),
    .up       (up),
    .dn       (dn)
  );

  pfd_charge #(
    .MAG_W (MAG_W),
    .ACC_W (ACC_W)
  ) u_charge (
    .clk      (clk),
    .rst_n    (rst_n),
    .up       (up),
    .dn       (dn),
    .pump_mag (pump_mag),
    .pump_val (pump_val),
    .charge   (charge)
  );

  pfd_lock_mon #(
    .THR_W        (THR_W),
    .LOCK_PERIODS (LOCK_PERIODS)
  ) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_edge (ref_edge),
    .up       (up),
    .dn       (dn),
    .lock_thr (lock_thr),
    .locked   (locked)
  );

endmodule

// File: rtl/pfd_pump_chk.sv
module pfd_pump_chk #(
  parameter int unsigned MAG_W = 8,
  parameter int unsigned ACC_W = 24
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ref_edge,
  input logic                    fb_edge,
  input logic                    up,
  input logic                    dn,
  input logic signed [MAG_W:0]   pump_val,
  input logic signed [ACC_W-1:0] charge,
  input logic                    locked
);

  a_r3_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(up && dn));

  a_r2_hold_no_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_edge || fb_edge) |=> ($stable(up) && $stable(dn)));

  a_r5_fb_clears_up: assert property (@(posedge clk) disable iff (!rst_n)
    (fb_edge && !ref_edge) |=> !up);

  a_r5_ref_clears_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && !fb_edge) |=> !dn);

  a_r6_coincident: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_edge && fb_edge) |=> (!up && !dn));

  a_r9_rise_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_val > 0) |=> (charge >= $past(charge)));

  a_r9_fall_dir: assert property (@(posedge clk) disable iff (!rst_n)
    (pump_val < 0) |=> (charge <= $past(charge)));

  a_r11_lock_on_ref: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_edge));

endmodule

bind pfd_pump_top pfd_pump_chk #(
  .MAG_W (MAG_W),
  .ACC_W (ACC_W)
) u_pfd_pump_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ref_edge (ref_edge),
  .fb_edge  (fb_edge),
  .up       (up),
  .dn       (dn),
  .pump_val (pump_val),
  .charge   (charge),
  .locked   (locked)
);

// File: tb/test_pfd_pump_top.sv
module test_pfd_pump_top;

  localparam int MAG_W = 8;
  localparam int ACC_W = 24;
  localparam int THR_W = 6;
  localparam longint CH_MAX = 64'sd8388607;
  localparam longint CH_MIN = -64'sd8388608;

  logic                    clk;
  logic                    rst_n;
  logic                    ref_in;
  logic                    fb_in;
  logic [MAG_W-1:0]        pump_mag;
  logic [THR_W-1:0]        lock_thr;
  logic                    up;
  logic                    dn;
  logic signed [MAG_W:0]   pump_val;
  logic signed [ACC_W-1:0] charge;
  logic                    locked;

  int n_vec;
  int n_fail;
  int up_cnt;
  int dn_cnt;
  bit mon_en;

  pfd_pump_top #(
    .MAG_W (MAG_W),
    .ACC_W (ACC_W),
    .THR_W (THR_W)
  ) i_pfd_pump_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_in   (ref_in),
    .fb_in    (fb_in),
    .pump_mag (pump_mag),
    .lock_thr (lock_thr),
    .up       (up),
    .dn       (dn),
    .pump_val (pump_val),
    .charge   (charge),
    .locked   (locked)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle monitor: pulse counting, R3 exclusion and R8 pump value.
  always @(negedge clk) begin
    if (mon_en) begin
      longint exp_pv;
      up_cnt += int'(up);
      dn_cnt += int'(dn);
      chk(!(up && dn), "R3", longint'({up, dn}), 0);
      exp_pv = up ? longint'(pump_mag) : (dn ? -longint'(pump_mag) : 0);
      chk(longint'(pump_val) == exp_pv, "R8", longint'(pump_val), exp_pv);
    end
  end

  task automatic do_reset();
    @(negedge clk);
    mon_en = 1'b0;
    rst_n  = 1'b0;
    ref_in = 1'b0;
    fb_in  = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    up_cnt = 0;
    dn_cnt = 0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Single rising-edge pair: positive d means the reference leads by d cycles.
  task automatic pair_trial(input int d, input int mag);
    int ad;
    longint exp_q;
    ad = (d < 0) ? -d : d;
    do_reset();
    pump_mag = MAG_W'(mag);
    mon_en = 1'b1;
    if (d >= 0) ref_in = 1'b1; else fb_in = 1'b1;
    if (d == 0) fb_in = 1'b1;
    wait_n(ad);
    ref_in = 1'b1;
    fb_in  = 1'b1;
    wait_n(ad + 8);
    chk(up_cnt == ((d > 0) ? d : 0), "R4 up width", up_cnt, (d > 0) ? d : 0);
    chk(dn_cnt == ((d < 0) ? -d : 0), "R4 dn width", dn_cnt, (d < 0) ? -d : 0);
    exp_q = longint'(d) * longint'(mag);
    chk(longint'(charge) == exp_q, "R9 charge", longint'(charge), exp_q);
    mon_en = 1'b0;
  endtask

  // Periodic inputs, period 20; lead > 0 means the reference leads.
  task automatic periodic(input int lead, input int periods);
    for (int c = 0; c < periods * 20; c++) begin
      ref_in = ((c % 20) < 10);
      fb_in  = (((c + 40 - lead) % 20) < 10);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    n_vec = 0; n_fail = 0; up_cnt = 0; dn_cnt = 0; mon_en = 1'b0;
    rst_n = 1'b0; ref_in = 1'b0; fb_in = 1'b0;
    pump_mag = 8'd5; lock_thr = 6'd4;

    // R1: reset state, held and just after release
    repeat (2) @(negedge clk);
    chk({up, dn, locked} == 3'b000, "R1 pulses/lock in reset", longint'({up, dn, locked}), 0);
    chk(charge == 0 && pump_val == 0, "R1 charge in reset", longint'(charge), 0);
    do_reset();
    chk({up, dn, locked} == 3'b000 && charge == 0, "R1 after release", longint'(charge), 0);

    // R2: latency of three clock edges from the input rise to up
    do_reset();
    ref_in = 1'b1;
    @(negedge clk); chk(up == 1'b0, "R2 cycle1", longint'(up), 0);
    @(negedge clk); chk(up == 1'b0, "R2 cycle2", longint'(up), 0);
    @(negedge clk); chk(up == 1'b1, "R2 cycle3", longint'(up), 1);
    wait_n(5);
    chk(up == 1'b1, "R2 holds without edge", longint'(up), 1);

    // R4, R6, R8, R9: sweep of lead and lag, several magnitudes
    for (int m = 0; m < 3; m++) begin
      int mag;
      mag = (m == 0) ? 1 : ((m == 1) ? 7 : 255);
      for (int d = -12; d <= 12; d++) pair_trial(d, mag);
    end
    pair_trial(0, 200); // R6: coincident edges give no pulse

    // R5: a repeated reference edge stays in UP
    do_reset();
    pump_mag = 8'd2; mon_en = 1'b1;
    ref_in = 1'b1; wait_n(3);
    ref_in = 1'b0; wait_n(3);
    ref_in = 1'b1; wait_n(4);
    fb_in = 1'b1; wait_n(10);
    chk(up_cnt == 10, "R5 repeated ref stays up", up_cnt, 10);
    chk(dn_cnt == 0, "R5 repeated ref no dn", dn_cnt, 0);
    chk(charge == 20, "R5 repeated ref charge", longint'(charge), 20);
    // R5: a repeated feedback edge stays in DOWN
    do_reset();
    pump_mag = 8'd3; mon_en = 1'b1;
    fb_in = 1'b1; wait_n(2);
    fb_in = 1'b0; wait_n(4);
    fb_in = 1'b1; wait_n(3);
    ref_in = 1'b1; wait_n(10);
    chk(dn_cnt == 9, "R5 repeated fb stays dn", dn_cnt, 9);
    chk(up_cnt == 0, "R5 repeated fb no up", up_cnt, 0);
    chk(charge == -27, "R5 repeated fb charge", longint'(charge), -27);

    // R7: reference faster (10) than feedback (13), then the reverse
    do_reset();
    pump_mag = 8'd3; mon_en = 1'b1;
    for (int c = 0; c < 600; c++) begin
      ref_in = ((c % 10) < 5);
      fb_in  = ((c % 13) < 6);
      @(negedge clk);
    end
    chk(dn_cnt == 0, "R7 fast ref no dn", dn_cnt, 0);
    chk(up_cnt > 0, "R7 fast ref has up", up_cnt, 1);
    chk(charge > 0, "R7 fast ref charge positive", longint'(charge), 1);
    do_reset();
    mon_en = 1'b1;
    for (int c = 0; c < 600; c++) begin
      ref_in = ((c % 13) < 6);
      fb_in  = ((c % 10) < 5);
      @(negedge clk);
    end
    chk(up_cnt == 0, "R7 slow ref no up", up_cnt, 0);
    chk(dn_cnt > 0, "R7 slow ref has dn", dn_cnt, 1);
    chk(charge < 0, "R7 slow ref charge negative", longint'(charge), -1);

    // R11: threshold boundary, width equal to the threshold and one more
    for (int k = 0; k < 4; k++) begin
      int lead;
      bit exp_l;
      lead  = (k == 0) ? 4 : ((k == 1) ? 5 : ((k == 2) ? -4 : -5));
      exp_l = (k == 0 || k == 2);
      do_reset();
      lock_thr = 6'd4;
      periodic(lead, 10);
      chk(locked == 1'b0, "R11 not yet locked", longint'(locked), 0);
      periodic(lead, 10);
      chk(locked == exp_l, "R11 lock vs threshold", longint'(locked), longint'(exp_l));
      if (exp_l) begin
        periodic(9, 2);
        chk(locked == 1'b0, "R11 wide pulse drops lock", longint'(locked), 0);
      end
    end

    // R10: saturation at the positive limit, then at the negative limit
    do_reset();
    pump_mag = 8'd255;
    ref_in = 1'b1;
    wait_n(33000);
    chk(longint'(charge) == CH_MAX, "R10 positive limit", longint'(charge), CH_MAX);
    wait_n(50);
    chk(longint'(charge) == CH_MAX && up, "R10 stays at positive limit", longint'(charge), CH_MAX);
    chk(locked == 1'b0, "R11 long pulse no lock", longint'(locked), 0);
    fb_in = 1'b1; wait_n(6);
    chk(up == 1'b0 && dn == 1'b0, "R5 fb returns to neutral", longint'({up, dn}), 0);
    ref_in = 1'b0; fb_in = 1'b0; wait_n(4);
    fb_in = 1'b1;
    wait_n(66000);
    chk(longint'(charge) == CH_MIN, "R10 negative limit", longint'(charge), CH_MIN);
    wait_n(50);
    chk(longint'(charge) == CH_MIN && dn, "R10 stays at negative limit", longint'(charge), CH_MIN);
    ref_in = 1'b1; wait_n(6);
    chk(dn == 1'b0 && up == 1'b0, "R5 ref returns to neutral", longint'({up, dn}), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule